// File: doc/BRIEF.md
# Single-Entry Exclusive Access Monitor

This block keeps one address reservation for a load-exclusive / store-exclusive pair. A load-exclusive records the physical address of the access in a tag register and arms the reservation. A later store-exclusive checks its own address against that tag. It succeeds only when the addresses match and the reservation is armed. On success the store is allowed to write memory and the reservation is emptied. On failure the store is blocked and the requester receives a non-zero status.

The answer for a store-exclusive is combinational. The status bit and the write gate are valid in the same cycle as the store strobe, so the block sits directly beside the store path. An explicit clear input, for example from exception-return logic, drops the reservation without producing a status. The tag address is the physical address with its two low bits ORed with the two low bits of the virtual address. This keeps byte and halfword offsets inside the compared value.

Top module: `excl_monitor`

## Requirements
- R1: After reset the reservation is empty: the tag is all ones and the armed flag is clear, so any store-exclusive, including one to the all-ones address, fails.
- R2: A load-exclusive writes the tag with `{acc_pa[W-1:2], acc_pa[1:0] | acc_va_lo}` and arms the reservation; a later store that differs only in those two low bits fails.
- R3: A store-exclusive whose formed address equals the tag while the reservation is armed drives `stx_wr_en`=1 and `stx_status`=0 in the same cycle as `stx_vld`.
- R4: A successful store-exclusive empties the reservation (tag all ones, flag clear), so a repeat store to the same address fails.
- R5: A failing store-exclusive drives `stx_status`=1 and `stx_wr_en`=0 and leaves the reservation unchanged.
- R6: While `stx_vld` is low, both `stx_status` and `stx_wr_en` are 0.
- R7: `excl_clr` empties the reservation on the next edge and produces no status of its own.
- R8: When load and store strobes coincide, the store is judged against the old reservation, and the load then installs its address as the new armed reservation.
- R9: `excl_clr` overrides a load in the same cycle, so the reservation ends empty. A store in the same cycle as `excl_clr` is still judged against the old reservation.
- R10: The armed flag is separate from the tag value: a load-exclusive to the all-ones address arms a reservation, and a store to that address then succeeds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ldx_vld | input | 1 | Load-exclusive strobe |
| stx_vld | input | 1 | Store-exclusive strobe |
| excl_clr | input | 1 | Drop the reservation |
| acc_pa | input | ADDR_W | Physical address of the access |
| acc_va_lo | input | 2 | Low two bits of the virtual address |
| stx_status | output | 1 | 1 = store-exclusive failed, 0 = succeeded |
| stx_wr_en | output | 1 | Memory write permitted for this store |

## Verification
A wrong tag or armed flag never shows at the ports until a store-exclusive probes it. The bench therefore follows every load, clear and coincident-strobe case with stores to both the reserved address and a near miss, and compares the verdict in that same cycle. A reservation that fails to empty shows as a second success on a repeated store, one cycle after the first. A reservation that was lost shows as a failure where a success was expected. Random strobe mixes over a small address pool keep matches frequent, so stale state is caught within a few cycles.

// File: rtl/exmon_pkg.sv
package exmon_pkg;
  localparam int unsigned LO_W = 2;

  typedef struct packed {
    logic pass;
    logic fail;
  } stx_verdict_t;
endpackage

// File: rtl/exmon_addr_fmt.sv
module exmon_addr_fmt
  import exmon_pkg::*;
#(
  parameter int unsigned ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] pa,
  input  logic [LO_W-1:0]   va_lo,
  output logic [ADDR_W-1:0] addr
);
  // Offset bits from the virtual side are merged into the aligned physical word.
  always_comb begin
    addr = {pa[ADDR_W-1:LO_W], pa[LO_W-1:0] | va_lo};
  end
endmodule

// File: rtl/exmon_cmp.sv
module exmon_cmp
  import exmon_pkg::*;
#(
  parameter int unsigned ADDR_W  = 32,
  parameter int unsigned CHUNK_W = 8
) (
  input  logic              stx,
  input  logic              armed,
  input  logic [ADDR_W-1:0] addr,
  input  logic [ADDR_W-1:0] tag,
  output stx_verdict_t      verdict
);
  localparam int unsigned N_CHUNK = (ADDR_W + CHUNK_W - 1) / CHUNK_W;

  logic [N_CHUNK-1:0] chunk_eq;
  logic               tag_hit;

  // Equality split into chunks so the reduction tree stays balanced.
  for (genvar g = 0; g < N_CHUNK; g++) begin : g_chunk
    localparam int unsigned LO = g * CHUNK_W;
    localparam int unsigned HI = (LO + CHUNK_W > ADDR_W) ? ADDR_W - 1 : LO + CHUNK_W - 1;
    assign chunk_eq[g] = (addr[HI:LO] == tag[HI:LO]);
  end

  always_comb begin
    tag_hit      = &chunk_eq;
    verdict.pass = stx & armed & tag_hit;
    verdict.fail = stx & ~(armed & tag_hit);
  end
endmodule

// File: rtl/exmon_resv.sv
module exmon_resv #(
  parameter int unsigned ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              ldx,
  input  logic              hit,
  input  logic [ADDR_W-1:0] addr,
  output logic [ADDR_W-1:0] tag_q,
  output logic              armed_q
);
  localparam logic [ADDR_W-1:0] EMPTY = '1;

  logic [ADDR_W-1:0] tag_d;
  logic              armed_d;
  logic              upd_en;

  // Priority: clear, then load, then the effect of a successful store.
  always_comb begin
    tag_d   = tag_q;
    armed_d = armed_q;
    upd_en  = clr | ldx | hit;
    if (clr) begin
      tag_d   = EMPTY;
      armed_d = 1'b0;
    end else if (ldx) begin
      tag_d   = addr;
      armed_d = 1'b1;
    end else if (hit) begin
      tag_d   = EMPTY;
      armed_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tag_q   <= EMPTY;
      armed_q <= 1'b0;
    end else if (upd_en) begin
      tag_q   <= tag_d;
      armed_q <= armed_d;
    end
  end

  a_r10_empty_tag_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !armed_q |-> (tag_q == EMPTY));

  a_r2_load_installs: assert property (@(posedge clk) disable iff (!rst_n)
    (ldx && !clr) |=> (armed_q && tag_q == $past(addr)));

  a_r4_hit_empties: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && !ldx && !clr) |=> (!armed_q && tag_q == EMPTY));

  a_r7_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !armed_q);
endmodule

// File: rtl/excl_monitor.sv
module excl_monitor
  import exmon_pkg::*;
#(
  parameter int unsigned ADDR_W  = 32,
  parameter int unsigned CHUNK_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ldx_vld,
  input  logic              stx_vld,
  input  logic              excl_clr,
  input  logic [ADDR_W-1:0] acc_pa,
  input  logic [LO_W-1:0]   acc_va_lo,
  output logic              stx_status,
  output logic              stx_wr_en
);
  logic [ADDR_W-1:0] acc_addr;
  logic [ADDR_W-1:0] tag_q;
  logic              armed_q;
  stx_verdict_t      verdict;

  exmon_addr_fmt #(.ADDR_W(ADDR_W)) u_fmt (
    .pa    (acc_pa),
    .va_lo (acc_va_lo),
    .addr  (acc_addr)
  );

  exmon_cmp #(.ADDR_W(ADDR_W), .CHUNK_W(CHUNK_W)) u_cmp (
    .stx     (stx_vld),
    .armed   (armed_q),
    .addr    (acc_addr),
    .tag     (tag_q),
    .verdict (verdict)
  );

  exmon_resv #(.ADDR_W(ADDR_W)) u_resv (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (excl_clr),
    .ldx     (ldx_vld),
    .hit     (verdict.pass),
    .addr    (acc_addr),
    .tag_q   (tag_q),
    .armed_q (armed_q)
  );

  assign stx_wr_en  = verdict.pass;
  assign stx_status = verdict.fail;

  a_r6_quiet_without_store: assert property (@(posedge clk) disable iff (!rst_n)
    !stx_vld |-> (!stx_wr_en && !stx_status));

  a_r3_write_needs_reservation: assert property (@(posedge clk) disable iff (!rst_n)
    stx_wr_en |-> (armed_q && tag_q == acc_addr));

  a_r5_one_verdict: assert property (@(posedge clk) disable iff (!rst_n)
    stx_vld |-> (stx_wr_en != stx_status));
endmodule

// File: tb/sim_excl_monitor.sv
module sim_excl_monitor;
  localparam int unsigned AW = 32;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          ldx_vld, stx_vld, excl_clr;
  logic [AW-1:0] acc_pa;
  logic [1:0]    acc_va_lo;
  logic          stx_status, stx_wr_en;

  int n_cmp = 0;
  int n_bad = 0;

  logic [AW-1:0] m_tag = '1;
  logic          m_arm = 1'b0;

  always #2 clk = ~clk;

  excl_monitor #(.ADDR_W(AW)) u0 (
    .clk, .rst_n, .ldx_vld, .stx_vld, .excl_clr,
    .acc_pa, .acc_va_lo, .stx_status, .stx_wr_en
  );

  function automatic logic [AW-1:0] fmt(input logic [AW-1:0] pa, input logic [1:0] va);
    return {pa[AW-1:2], pa[1:0] | va};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step(input logic l, input logic s, input logic c,
                      input logic [AW-1:0] pa, input logic [1:0] va, input string req);
    logic exp_hit;
    @(posedge clk);
    #1;
    ldx_vld = l; stx_vld = s; excl_clr = c; acc_pa = pa; acc_va_lo = va;
    @(negedge clk);
    exp_hit = s && m_arm && (fmt(pa, va) == m_tag);
    check({req, " wr_en"},  {31'd0, stx_wr_en},  {31'd0, exp_hit});
    check({req, " status"}, {31'd0, stx_status}, {31'd0, s && !exp_hit});
    if (c) begin
      m_tag = '1; m_arm = 1'b0;
    end else if (l) begin
      m_tag = fmt(pa, va); m_arm = 1'b1;
    end else if (exp_hit) begin
      m_tag = '1; m_arm = 1'b0;
    end
  endtask

  initial begin
    #(200000 * 4);
    n_bad++;
    $display("FAIL watchdog actual running expected finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [AW-1:0] pool [4];
    void'($urandom(32'h5EED_0042));
    pool[0] = 32'h0000_1000; pool[1] = 32'h0000_1004;
    pool[2] = 32'h8000_0000; pool[3] = 32'hFFFF_FFFC;
    rst_n = 1'b0; ldx_vld = 0; stx_vld = 1; excl_clr = 0; acc_pa = '1; acc_va_lo = 2'd3;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 reset status", {31'd0, stx_status}, 32'd1);
    check("R1 reset wr_en",  {31'd0, stx_wr_en},  32'd0);
    stx_vld = 0;
    rst_n = 1'b1;

    step(0, 0, 0, 32'h0, 2'd0, "R6 idle");
    step(0, 1, 0, '1, 2'd3, "R1 store on empty");
    step(1, 0, 0, '1, 2'd0, "R10 load all-ones");
    step(0, 1, 0, '1, 2'd3, "R10 store all-ones");
    step(0, 1, 0, '1, 2'd3, "R4 repeat after success");
    step(1, 0, 0, 32'h0000_1000, 2'd2, "R2 load offset");
    step(0, 1, 0, 32'h0000_1000, 2'd0, "R2 low bits differ");
    step(0, 1, 0, 32'h0000_1000, 2'd2, "R3 matching store");
    step(1, 0, 0, 32'h0000_2000, 2'd0, "R5 load");
    step(0, 1, 0, 32'h0000_3000, 2'd0, "R5 mismatch store");
    step(0, 1, 0, 32'h0000_2000, 2'd0, "R5 reservation kept");
    step(1, 0, 0, 32'h0000_2000, 2'd0, "R7 load");
    step(0, 0, 1, 32'h0000_2000, 2'd0, "R7 clear quiet");
    step(0, 1, 0, 32'h0000_2000, 2'd0, "R7 store after clear");
    step(1, 0, 0, 32'h0000_4000, 2'd0, "R8 load");
    step(1, 1, 0, 32'h0000_5000, 2'd0, "R8 both, other addr");
    step(0, 1, 0, 32'h0000_5000, 2'd0, "R8 new reservation");
    step(1, 0, 0, 32'h0000_6000, 2'd1, "R8 load");
    step(1, 1, 0, 32'h0000_6000, 2'd1, "R8 both, same addr");
    step(0, 1, 0, 32'h0000_6000, 2'd1, "R8 re-armed");
    step(1, 0, 0, 32'h0000_7000, 2'd0, "R9 load");
    step(1, 0, 1, 32'h0000_8000, 2'd0, "R9 clear beats load");
    step(0, 1, 0, 32'h0000_8000, 2'd0, "R9 store after clear+load");
    step(1, 0, 0, 32'h0000_9000, 2'd0, "R9 load");
    step(0, 1, 1, 32'h0000_9000, 2'd0, "R9 store with clear");
    step(0, 1, 0, 32'h0000_9000, 2'd0, "R9 emptied");

    for (int i = 0; i < 4000; i++) begin
      logic [2:0] r;
      r = 3'($urandom_range(7));
      step(r == 3'd0 || r == 3'd1 || r == 3'd7, r >= 3'd2 && r <= 3'd5 || r == 3'd7,
           $urandom_range(15) == 0, pool[$urandom_range(3)], 2'($urandom_range(1)),
           "R3 R5 random");
    end
    step(0, 0, 0, 32'h0, 2'd0, "R6 idle end");

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule